// File: doc/BRIEF.md
# Flash Command Staging and Dispatch

This block is the firmware-facing command port of a multi-bank NAND flash controller. Software fills a bank of staging registers with one operation: opcode, target bank, option flags, DMA buffer address and byte count, column, row, and the destination column and row used by copyback. It then writes the issue register. That write copies the whole staged set into a one-entry holding slot and stamps it with an auto-incremented sequence number.

The slot keeps the command until its target bank reports idle, and one cycle later it presents the command on the dispatch outputs. A bank value of 0x3F asks the slot to choose a bank itself. In that case it waits for any idle bank, takes the lowest-numbered one, and records the choice in a readable register. The staging registers are independent of the slot, so software may prepare the next command while the current one waits. Software reads the slot status to learn when the slot is free again.

Top module: `flash_cmd_stage`

## Requirements
- R1: After reset the status register reads 0, the command ID register reads 0, the chosen-bank register reads 0, and `dsp_valid` is low.
- R2: Register offsets are as follows. 0x00 opcode (8 bits), 0x04 bank (6 bits), 0x08 options (9 bits; option values are one-hot codes such as 0x001 two-plane and 0x008 scrambler), 0x0C DMA address, 0x10 DMA count, 0x14 column, 0x18 row, 0x1C destination column, 0x20 destination row, 0x24 command ID (read only), 0x28 issue (write only), 0x2C status, 0x30 chosen bank. A written field reads back with the bits above its width returned as zero.
- R3: DMA address, DMA count, column and destination column keep only 512-byte multiples: their low 9 bits always read back as zero.
- R4: A write of any value to the issue register while the slot is empty fills the slot. Status bit 0 reads 1 from the next cycle, and the command ID becomes one more than before. The command carries that ID.
- R5: For a bank value other than 0x3F, the slot holds the command until `bank_idle` of that bank is high at a clock edge. It then drives `dsp_valid` in the following cycle, with that bank and with the field values captured at issue. Staging writes made after issue do not alter them.
- R6: With bank value 0x3F, the command goes to the lowest-numbered bank whose `bank_idle` is high at the first edge that has any idle bank. The chosen-bank register reads the bank that received the last dispatched command.
- R7: An issue write while the slot is occupied is dropped. Status bit 1 (overflow) sets and stays set until reset. The command ID and the waiting command are unchanged.
- R8: `dsp_valid` is high for exactly one cycle per dispatch. Status bit 0 reads 0 in that cycle.
- R9: A bank value other than 0x3F selects the bank given by its low log2(NUM_BANKS) bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | ADDR_W | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| bank_idle | input | NUM_BANKS | Per-bank idle indication |
| dsp_valid | output | 1 | One-cycle dispatch pulse |
| dsp_bank | output | log2(NUM_BANKS) | Bank receiving the command |
| dsp_opcode | output | 8 | Dispatched opcode |
| dsp_opts | output | 9 | Dispatched option flags |
| dsp_dma_addr | output | 32 | Dispatched DMA buffer address |
| dsp_dma_cnt | output | 32 | Dispatched DMA byte count |
| dsp_col | output | 32 | Dispatched column |
| dsp_row | output | 32 | Dispatched row |
| dsp_dst_col | output | 32 | Dispatched copyback destination column |
| dsp_dst_row | output | 32 | Dispatched copyback destination row |
| dsp_id | output | 16 | Sequence number of the dispatched command |

## Verification
The hardest case to reach is an issue write that lands while a command is still waiting. The bench produces it by holding every `bank_idle` low after a first issue and rewriting the staging opcode. It then issues again. Only after that does it release the target bank, so the dispatched opcode and ID show whether the dropped write leaked into the slot. A fixed-bank wait is forced in a similar way: every bank except the target is held idle for several cycles, so a dispatch to the wrong bank would show up at once.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the flash command staging block.
// Assumes a 32-bit register bus and byte offsets on a word grid.
package fcs_pkg;
    localparam int DW         = 32;
    localparam int OPC_W      = 8;
    localparam int OPT_W      = 9;
    localparam int BANK_W     = 6;
    localparam int ID_W       = 16;
    localparam int ALIGN_BITS = 9;
    localparam logic [BANK_W-1:0] BANK_AUTO = 6'h3F;

    localparam int OFS_OPC    = 'h00;
    localparam int OFS_BANK   = 'h04;
    localparam int OFS_OPT    = 'h08;
    localparam int OFS_DADDR  = 'h0C;
    localparam int OFS_DCNT   = 'h10;
    localparam int OFS_COL    = 'h14;
    localparam int OFS_ROW    = 'h18;
    localparam int OFS_DCOL   = 'h1C;
    localparam int OFS_DROW   = 'h20;
    localparam int OFS_ID     = 'h24;
    localparam int OFS_ISSUE  = 'h28;
    localparam int OFS_STAT   = 'h2C;
    localparam int OFS_CHOSEN = 'h30;

    // Command body carried from staging to dispatch (bank kept separately).
    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [OPT_W-1:0] opts;
        logic [DW-1:0]    dma_addr;
        logic [DW-1:0]    dma_cnt;
        logic [DW-1:0]    col;
        logic [DW-1:0]    row;
        logic [DW-1:0]    dst_col;
        logic [DW-1:0]    dst_row;
    } cmd_t;
endpackage

// File: rtl/flash_cmd_regs.sv
`timescale 1ns/1ps
// Staging register file: holds the command being prepared by software,
// decodes the issue strobe and muxes all readable registers.
// Assumes single-cycle writes; reads are combinational.
module flash_cmd_regs
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BIDX_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DW-1:0]      rd_data,
    input  logic               slot_busy,
    input  logic               overflow,
    input  logic [ID_W-1:0]    cmd_id,
    input  logic [BIDX_W-1:0]  chosen_bank,
    output cmd_t               staged,
    output logic [BANK_W-1:0]  staged_bank,
    output logic               issue_stb
);
    localparam logic [ALIGN_BITS-1:0] ZERO_LOW = '0;

    logic [DW-1:0] aligned_data;
    assign aligned_data = {wr_data[DW-1:ALIGN_BITS], ZERO_LOW};
    assign issue_stb    = wr_en && (wr_addr == ADDR_W'(OFS_ISSUE));

    // Capture software writes into the staging registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged      <= '0;
            staged_bank <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(OFS_OPC):   staged.opcode   <= wr_data[OPC_W-1:0];
                ADDR_W'(OFS_BANK):  staged_bank     <= wr_data[BANK_W-1:0];
                ADDR_W'(OFS_OPT):   staged.opts     <= wr_data[OPT_W-1:0];
                ADDR_W'(OFS_DADDR): staged.dma_addr <= aligned_data;
                ADDR_W'(OFS_DCNT):  staged.dma_cnt  <= aligned_data;
                ADDR_W'(OFS_COL):   staged.col      <= aligned_data;
                ADDR_W'(OFS_ROW):   staged.row      <= wr_data;
                ADDR_W'(OFS_DCOL):  staged.dst_col  <= aligned_data;
                ADDR_W'(OFS_DROW):  staged.dst_row  <= wr_data;
                default: ;
            endcase
        end
    end

    // Select the register addressed by the read port.
    always_comb begin
        case (rd_addr)
            ADDR_W'(OFS_OPC):    rd_data = {{(DW-OPC_W){1'b0}}, staged.opcode};
            ADDR_W'(OFS_BANK):   rd_data = {{(DW-BANK_W){1'b0}}, staged_bank};
            ADDR_W'(OFS_OPT):    rd_data = {{(DW-OPT_W){1'b0}}, staged.opts};
            ADDR_W'(OFS_DADDR):  rd_data = staged.dma_addr;
            ADDR_W'(OFS_DCNT):   rd_data = staged.dma_cnt;
            ADDR_W'(OFS_COL):    rd_data = staged.col;
            ADDR_W'(OFS_ROW):    rd_data = staged.row;
            ADDR_W'(OFS_DCOL):   rd_data = staged.dst_col;
            ADDR_W'(OFS_DROW):   rd_data = staged.dst_row;
            ADDR_W'(OFS_ID):     rd_data = {{(DW-ID_W){1'b0}}, cmd_id};
            ADDR_W'(OFS_STAT):   rd_data = {{(DW-2){1'b0}}, overflow, slot_busy};
            ADDR_W'(OFS_CHOSEN): rd_data = {{(DW-BIDX_W){1'b0}}, chosen_bank};
            default:             rd_data = '0;
        endcase
    end
endmodule

// File: rtl/flash_bank_pick.sv
`timescale 1ns/1ps
// Fixed-priority picker: finds the lowest-numbered idle bank.
// Assumes NUM_BANKS >= 2; purely combinational apart from its checks.
module flash_bank_pick #(
    parameter int NUM_BANKS = 8,
    parameter int BIDX_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] idle,
    output logic                 found,
    output logic [BIDX_W-1:0]    idx
);
    logic [NUM_BANKS:0]   seen;
    logic [NUM_BANKS-1:0] grant;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chain
        assign seen[g+1] = seen[g] | idle[g];
        assign grant[g]  = idle[g] & ~seen[g];
    end
    assign found = seen[NUM_BANKS];

    // Encode the single granted bank into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (grant[i]) idx = BIDX_W'(i);
        end
    end

    // R6
    pick_grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R6
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> idle[idx] && ((idle & ((NUM_BANKS'(1) << idx) - 1'b1)) == '0));
endmodule

// File: rtl/flash_cmd_slot.sv
`timescale 1ns/1ps
// One-entry waiting slot: accepts an issued command when empty, tags it
// with a sequence ID, waits for its bank (or any bank in autoselect) and
// emits a one-cycle dispatch. Assumes the picker sees the live idle vector.
module flash_cmd_slot
    import fcs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BIDX_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_stb,
    input  cmd_t                 staged,
    input  logic [BANK_W-1:0]    staged_bank,
    input  logic [NUM_BANKS-1:0] bank_idle,
    input  logic                 pick_found,
    input  logic [BIDX_W-1:0]    pick_idx,
    output logic                 busy,
    output logic                 overflow,
    output logic [ID_W-1:0]      last_id,
    output logic [BIDX_W-1:0]    chosen_bank,
    output logic                 dsp_valid,
    output logic [BIDX_W-1:0]    dsp_bank,
    output cmd_t                 dsp_cmd,
    output logic [ID_W-1:0]      dsp_id
);
    cmd_t              held;
    logic [BANK_W-1:0] held_bank;
    logic [ID_W-1:0]   held_id;
    logic              is_auto;
    logic [BIDX_W-1:0] fixed_idx;
    logic              ready;
    logic [BIDX_W-1:0] tgt;

    assign is_auto   = (held_bank == BANK_AUTO);
    assign fixed_idx = held_bank[BIDX_W-1:0];
    assign ready     = busy && (is_auto ? pick_found : bank_idle[fixed_idx]);
    assign tgt       = is_auto ? pick_idx : fixed_idx;

    // Accept, hold and release commands; track ID and overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            overflow    <= 1'b0;
            last_id     <= '0;
            held        <= '0;
            held_bank   <= '0;
            held_id     <= '0;
            chosen_bank <= '0;
            dsp_valid   <= 1'b0;
            dsp_bank    <= '0;
            dsp_cmd     <= '0;
            dsp_id      <= '0;
        end else begin
            dsp_valid <= 1'b0;
            if (ready) begin
                busy        <= 1'b0;
                dsp_valid   <= 1'b1;
                dsp_bank    <= tgt;
                chosen_bank <= tgt;
                dsp_cmd     <= held;
                dsp_id      <= held_id;
            end
            if (issue_stb) begin
                if (busy) begin
                    overflow <= 1'b1;
                end else begin
                    busy      <= 1'b1;
                    held      <= staged;
                    held_bank <= staged_bank;
                    held_id   <= last_id + 1'b1;
                    last_id   <= last_id + 1'b1;
                end
            end
        end
    end

    // R4
    accept_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_stb && !busy) |=> busy && last_id == $past(last_id) + 1'b1);
    // R5
    wait_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_auto && !bank_idle[fixed_idx]) |=> busy && !dsp_valid);
    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R7
    drop_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_stb && busy) |=> overflow && $stable(last_id) && held == $past(held));
    // R8
    dsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |=> !dsp_valid);
    // R8
    dsp_frees_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |-> !busy);
endmodule

// File: rtl/flash_cmd_stage.sv
`timescale 1ns/1ps
// Top of the flash command staging and dispatch block: staging registers,
// waiting slot and lowest-idle bank picker. Assumes bank_idle is
// synchronous to clk.
module flash_cmd_stage
    import fcs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 12,
    localparam int BIDX_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_wr_addr,
    input  logic [31:0]          reg_wr_data,
    input  logic [ADDR_W-1:0]    reg_rd_addr,
    output logic [31:0]          reg_rd_data,
    input  logic [NUM_BANKS-1:0] bank_idle,
    output logic                 dsp_valid,
    output logic [BIDX_W-1:0]    dsp_bank,
    output logic [7:0]           dsp_opcode,
    output logic [8:0]           dsp_opts,
    output logic [31:0]          dsp_dma_addr,
    output logic [31:0]          dsp_dma_cnt,
    output logic [31:0]          dsp_col,
    output logic [31:0]          dsp_row,
    output logic [31:0]          dsp_dst_col,
    output logic [31:0]          dsp_dst_row,
    output logic [15:0]          dsp_id
);
    cmd_t              staged;
    cmd_t              dsp_cmd;
    logic [BANK_W-1:0] staged_bank;
    logic              issue_stb;
    logic              busy;
    logic              overflow;
    logic [ID_W-1:0]   last_id;
    logic [BIDX_W-1:0] chosen_bank;
    logic              pick_found;
    logic [BIDX_W-1:0] pick_idx;

    flash_cmd_regs #(.ADDR_W(ADDR_W), .BIDX_W(BIDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .slot_busy(busy), .overflow(overflow), .cmd_id(last_id),
        .chosen_bank(chosen_bank),
        .staged(staged), .staged_bank(staged_bank), .issue_stb(issue_stb)
    );

    flash_bank_pick #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .idle(bank_idle),
        .found(pick_found), .idx(pick_idx)
    );

    flash_cmd_slot #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .issue_stb(issue_stb), .staged(staged), .staged_bank(staged_bank),
        .bank_idle(bank_idle), .pick_found(pick_found), .pick_idx(pick_idx),
        .busy(busy), .overflow(overflow), .last_id(last_id),
        .chosen_bank(chosen_bank),
        .dsp_valid(dsp_valid), .dsp_bank(dsp_bank),
        .dsp_cmd(dsp_cmd), .dsp_id(dsp_id)
    );

    assign dsp_opcode   = dsp_cmd.opcode;
    assign dsp_opts     = dsp_cmd.opts;
    assign dsp_dma_addr = dsp_cmd.dma_addr;
    assign dsp_dma_cnt  = dsp_cmd.dma_cnt;
    assign dsp_col      = dsp_cmd.col;
    assign dsp_row      = dsp_cmd.row;
    assign dsp_dst_col  = dsp_cmd.dst_col;
    assign dsp_dst_row  = dsp_cmd.dst_row;
endmodule

// File: tb/flash_cmd_stage_tb.sv
`timescale 1ns/1ps
// Self-checking bench: vector table for dispatch targets, then directed tests.
module flash_cmd_stage_tb;
    localparam int NB = 8;
    localparam int AW = 12;
    localparam int NVEC = 6;
    // {bank[5:0], idle mask[7:0], expected bank[2:0]}
    localparam logic [16:0] VECS [NVEC] = '{
        {6'd3,  8'h08, 3'd3},
        {6'd0,  8'hFF, 3'd0},
        {6'h3F, 8'h24, 3'd2},
        {6'h3F, 8'h80, 3'd7},
        {6'd11, 8'h08, 3'd3},
        {6'h3F, 8'hFF, 3'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NB-1:0] bank_idle = '0;
    logic          dsp_valid;
    logic [2:0]    dsp_bank;
    logic [7:0]    dsp_opcode;
    logic [8:0]    dsp_opts;
    logic [31:0]   dsp_dma_addr, dsp_dma_cnt, dsp_col, dsp_row, dsp_dst_col, dsp_dst_row;
    logic [15:0]   dsp_id;

    int errs = 0;
    int checks = 0;
    int exp_id = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_stage #(.NUM_BANKS(NB), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
        .bank_idle(bank_idle),
        .dsp_valid(dsp_valid), .dsp_bank(dsp_bank), .dsp_opcode(dsp_opcode),
        .dsp_opts(dsp_opts), .dsp_dma_addr(dsp_dma_addr), .dsp_dma_cnt(dsp_dma_cnt),
        .dsp_col(dsp_col), .dsp_row(dsp_row), .dsp_dst_col(dsp_dst_col),
        .dsp_dst_row(dsp_dst_row), .dsp_id(dsp_id)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input string req, input int addr, input logic [31:0] exp);
        rd_addr = AW'(addr);
        #0.1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        rdchk("R1 status", 'h2C, 0);
        rdchk("R1 id", 'h24, 0);
        rdchk("R1 chosen", 'h30, 0);
        chk("R1 dsp_valid", 32'(dsp_valid), 0);
        rst_n = 1'b1;

        // R2: register readback and width masking
        wr('h00, 32'hFFFF_FFAB); rdchk("R2 opcode", 'h00, 32'hAB);
        wr('h04, 32'hFFFF_FFFF); rdchk("R2 bank", 'h04, 32'h3F);
        wr('h08, 32'hFFFF_FFFF); rdchk("R2 options", 'h08, 32'h1FF);
        wr('h08, 32'h0000_0008); rdchk("R2 options onehot", 'h08, 32'h008);
        wr('h18, 32'hDEAD_BEEF); rdchk("R2 row", 'h18, 32'hDEAD_BEEF);
        wr('h20, 32'h0BAD_F00D); rdchk("R2 dst row", 'h20, 32'h0BAD_F00D);

        // R3: 512-byte alignment
        wr('h0C, 32'h1234_5FFF); rdchk("R3 dma addr", 'h0C, 32'h1234_5E00);
        wr('h10, 32'h0000_0A01); rdchk("R3 dma cnt", 'h10, 32'h0000_0A00);
        wr('h14, 32'h0000_03FF); rdchk("R3 col", 'h14, 32'h0000_0200);
        wr('h1C, 32'h0000_01FF); rdchk("R3 dst col", 'h1C, 32'h0);

        // R4 R5 R6 R9: table-driven dispatch targets
        for (int i = 0; i < NVEC; i++) begin
            bank_idle = '0;
            wr('h00, 32'h10 + 32'(i));
            wr('h04, {26'd0, VECS[i][16:11]});
            wr('h28, 32'h0);
            exp_id++;
            rdchk("R4 busy after issue", 'h2C, 32'h1);
            rdchk("R4 id increments", 'h24, 32'(exp_id));
            bank_idle = VECS[i][10:3];
            @(negedge clk);
            chk("R5 R6 dispatch valid", 32'(dsp_valid), 1);
            chk("R6 R9 dispatch bank", 32'(dsp_bank), 32'(VECS[i][2:0]));
            chk("R5 dispatch opcode", 32'(dsp_opcode), 32'h10 + 32'(i));
            chk("R4 dispatch id", 32'(dsp_id), 32'(exp_id));
            rdchk("R6 chosen bank", 'h30, 32'(VECS[i][2:0]));
            rdchk("R8 slot free at dispatch", 'h2C, 32'h0);
            @(negedge clk);
            chk("R8 single-cycle pulse", 32'(dsp_valid), 0);
        end

        // R5: wait for a busy fixed bank, snapshot at issue
        bank_idle = '0;
        wr('h00, 32'h21);
        wr('h04, 32'h5);
        wr('h18, 32'h0000_1000);
        wr('h28, 32'h0);
        exp_id++;
        bank_idle = 8'hDF;
        wr('h00, 32'h55);
        wr('h18, 32'h0000_2000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 no dispatch while bank busy", 32'(dsp_valid), 0);
            rdchk("R5 slot still occupied", 'h2C, 32'h1);
        end
        bank_idle = 8'h20;
        @(negedge clk);
        chk("R5 dispatch on idle", 32'(dsp_valid), 1);
        chk("R5 bank", 32'(dsp_bank), 5);
        chk("R5 opcode snapshot", 32'(dsp_opcode), 32'h21);
        chk("R5 row snapshot", dsp_row, 32'h0000_1000);

        // R7: issue while occupied is dropped
        bank_idle = '0;
        wr('h04, 32'h2);
        wr('h00, 32'h31);
        wr('h28, 32'h0);
        exp_id++;
        wr('h00, 32'h77);
        wr('h28, 32'h0);
        rdchk("R7 overflow and busy", 'h2C, 32'h3);
        rdchk("R7 id unchanged", 'h24, 32'(exp_id));
        bank_idle = 8'h04;
        @(negedge clk);
        chk("R7 dispatch valid", 32'(dsp_valid), 1);
        chk("R7 slot kept first opcode", 32'(dsp_opcode), 32'h31);
        chk("R7 slot kept first id", 32'(dsp_id), 32'(exp_id));
        rdchk("R7 overflow sticky", 'h2C, 32'h2);
        @(negedge clk);
        rdchk("R7 overflow still set", 'h2C, 32'h2);

        // R1: reset clears everything again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rdchk("R1 status after reset", 'h2C, 0);
        rdchk("R1 id after reset", 'h24, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule